// File: doc/BRIEF.md
# USB IN Endpoint Buffer Controller

This block runs one device-side USB IN endpoint. It sits between the firmware, which fills packet buffers and issues commands, and a protocol engine, which reports IN tokens and host acknowledgements. It tracks up to two committed packets and counts the bytes of a packet still being loaded. For each IN token it chooses the reply: data with the current toggle, NAK, STALL or a zero-length packet.

Firmware sets the endpoint type (bulk/interrupt or isochronous), double buffering, automatic commit of full-size packets and the maximum packet size in units of 8 bytes. It drives the endpoint through one-cycle command pulses: commit, flush, clear toggle, force toggle and clear of each flag. It reads back two sticky flags, the packet-ready and packet-present status, and a one-cycle interrupt pulse. Replies are registered and appear one cycle after the token.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, no packet is held, the toggle is 0, both sticky flags are 0 and there is no reply or interrupt.
- R2: A commit pulse adds one packet when there is room. Room is 1 packet, or 2 when double buffering is on; a commit with no room is ignored. pkt_ready is 1 whenever at least one committed packet is held.
- R3: One cycle after tok_in, resp_valid is 1 for one cycle. With a packet held, resp_kind is 0 (data) and resp_tog carries the data toggle held at the token.
- R4: In bulk mode a data reply waits for host_ack. That ack retires the oldest packet and flips data_tog. An ack with no data in flight has no effect.
- R5: In isochronous mode a data reply retires the packet and flips data_tog at once, without an ack.
- R6: A token with no packet held sets the sticky underrun flag. The reply is 1 (NAK) in bulk mode and 3 (zero-length) in isochronous mode. The flag stays until its clear pulse.
- R7: With cfg_stall high in bulk mode every token gets reply 2 (STALL). The stall reply sets the sticky sent_stall flag and drops every packet and any partly loaded bytes. The flag stays until its clear pulse.
- R8: In isochronous mode cfg_stall has no effect on the reply.
- R9: Each flush pulse drops one packet, the oldest. With no packet committed it drops the partly loaded bytes.
- R10: With auto-ready on, the byte that brings the loaded count to cfg_max_units*8 commits the packet by itself.
- R11: A clear-toggle pulse sets data_tog to 0.
- R12: A force-toggle pulse flips data_tog and drops the oldest packet, if there is one.
- R13: pkt_present is 1 whenever a committed packet or a partly loaded byte is held.
- R14: irq pulses for one cycle after a packet is retired by R4 or R5 and after a STALL reply, but only if irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| cfg_dbl_buf | input | 1 | Allows a second packet slot |
| cfg_auto_ready | input | 1 | Commits a full-size packet automatically |
| cfg_max_units | input | MAXU_W | Maximum packet size in 8-byte units |
| cfg_stall | input | 1 | Requests STALL replies |
| irq_en | input | 1 | Enables the interrupt pulse |
| fw_set_ready | input | 1 | Commits the loaded packet |
| fw_flush | input | 1 | Drops the oldest packet |
| fw_clr_tog | input | 1 | Sets the toggle to 0 |
| fw_force_tog | input | 1 | Flips the toggle and drops the oldest packet |
| fw_clr_sent_stall | input | 1 | Clears sent_stall |
| fw_clr_underrun | input | 1 | Clears underrun |
| load_byte | input | 1 | One byte written into the buffer |
| tok_in | input | 1 | IN token received |
| host_ack | input | 1 | Host ACK received |
| resp_valid | output | 1 | Reply is valid this cycle |
| resp_kind | output | 2 | 0 data, 1 NAK, 2 STALL, 3 zero-length |
| resp_tog | output | 1 | Data toggle for the reply |
| pkt_ready | output | 1 | At least one committed packet |
| pkt_present | output | 1 | Any committed packet or partial data |
| sent_stall | output | 1 | Sticky flag: STALL was sent |
| underrun | output | 1 | Sticky flag: token found no packet |
| data_tog | output | 1 | Current data toggle |
| irq | output | 1 | Endpoint interrupt pulse |

## Verification
The checks that run on every cycle are these. A token always gets a reply on the next cycle. A STALL reply comes with the sent_stall flag set and the buffer empty. A NAK or zero-length reply comes with the underrun flag set. STALL never answers a token taken in isochronous mode. irq fires only when it was enabled. A clear-toggle pulse on its own leaves the toggle at 0. Only the bench scenarios can show the rest: which packet a flush or force-toggle drops, capacity in single and double buffering, auto-commit on exactly the last byte, and the toggle sequence over acked and isochronous sends.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
    typedef enum logic [1:0] {
        RESP_DATA  = 2'd0,
        RESP_NAK   = 2'd1,
        RESP_STALL = 2'd2,
        RESP_ZLP   = 2'd3
    } resp_e;

    typedef struct packed {
        logic [1:0] rdy;
        logic       tog;
        logic       inflight;
        logic       sent_stall;
        logic       underrun;
        logic       rv;
        resp_e      kind;
        logic       rtog;
        logic       irq;
    } ep_state_t;
endpackage

// File: rtl/usb_in_ep_fill.sv
module usb_in_ep_fill #(
    parameter int MAXU_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_en,
    input  logic                clear,
    input  logic                auto_en,
    input  logic [MAXU_W-1:0]   max_units,
    output logic                auto_commit,
    output logic                partial
);
    localparam int FILL_W = MAXU_W + 3;

    logic [FILL_W-1:0] fill_d, fill_q;
    logic [FILL_W-1:0] fill_inc;
    logic [FILL_W-1:0] target;

    always_comb begin
        fill_inc    = fill_q + 1'b1;
        target      = {max_units, 3'b000};
        auto_commit = byte_en && auto_en && (max_units != '0) && (fill_inc == target);
        fill_d      = fill_q;
        if (byte_en)
            fill_d = fill_inc;
        if (clear || auto_commit)
            fill_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else
            fill_q <= fill_d;
    end

    assign partial = (fill_q != '0);
endmodule

// File: rtl/usb_in_ep_reply.sv
module usb_in_ep_reply
    import usb_in_ep_pkg::*;
(
    input  logic  stall_req,
    input  logic  iso,
    input  logic  have_pkt,
    output resp_e kind
);
    always_comb begin
        if (stall_req && !iso)
            kind = RESP_STALL;
        else if (have_pkt)
            kind = RESP_DATA;
        else if (iso)
            kind = RESP_ZLP;
        else
            kind = RESP_NAK;
    end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int MAXU_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_iso,
    input  logic              cfg_dbl_buf,
    input  logic              cfg_auto_ready,
    input  logic [MAXU_W-1:0] cfg_max_units,
    input  logic              cfg_stall,
    input  logic              irq_en,
    input  logic              fw_set_ready,
    input  logic              fw_flush,
    input  logic              fw_clr_tog,
    input  logic              fw_force_tog,
    input  logic              fw_clr_sent_stall,
    input  logic              fw_clr_underrun,
    input  logic              load_byte,
    input  logic              tok_in,
    input  logic              host_ack,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic              resp_tog,
    output logic              pkt_ready,
    output logic              pkt_present,
    output logic              sent_stall,
    output logic              underrun,
    output logic              data_tog,
    output logic              irq
);
    localparam logic [1:0] SLOTS_SINGLE = 2'd1;
    localparam logic [1:0] SLOTS_DOUBLE = 2'd2;

    ep_state_t st_d, st_q;
    resp_e     sel_kind;
    logic      has_space;
    logic      byte_en;
    logic      fill_clr;
    logic      auto_commit;
    logic      partial;
    logic      event_irq;

    assign has_space = st_q.rdy < (cfg_dbl_buf ? SLOTS_DOUBLE : SLOTS_SINGLE);
    assign byte_en   = load_byte && has_space;

    usb_in_ep_reply reply_i (
        .stall_req (cfg_stall),
        .iso       (cfg_iso),
        .have_pkt  (st_q.rdy != 2'd0),
        .kind      (sel_kind)
    );

    usb_in_ep_fill #(.MAXU_W(MAXU_W)) fill_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_en     (byte_en),
        .clear       (fill_clr),
        .auto_en     (cfg_auto_ready),
        .max_units   (cfg_max_units),
        .auto_commit (auto_commit),
        .partial     (partial)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        fill_clr  = 1'b0;
        event_irq = 1'b0;

        if (tok_in) begin
            st_d.rv   = 1'b1;
            st_d.kind = sel_kind;
            st_d.rtog = st_q.tog;
            case (sel_kind)
                RESP_STALL: begin
                    st_d.sent_stall = 1'b1;
                    st_d.rdy        = 2'd0;
                    st_d.inflight   = 1'b0;
                    fill_clr        = 1'b1;
                    event_irq       = 1'b1;
                end
                RESP_DATA: begin
                    if (cfg_iso) begin
                        st_d.rdy  = st_q.rdy - 2'd1;
                        st_d.tog  = ~st_q.tog;
                        event_irq = 1'b1;
                    end else begin
                        st_d.inflight = 1'b1;
                    end
                end
                default: st_d.underrun = 1'b1;
            endcase
        end

        if (host_ack && st_q.inflight && !cfg_iso && st_d.rdy != 2'd0) begin
            st_d.rdy      = st_d.rdy - 2'd1;
            st_d.tog      = ~st_d.tog;
            st_d.inflight = 1'b0;
            event_irq     = 1'b1;
        end

        if ((fw_set_ready && has_space) || auto_commit) begin
            st_d.rdy = st_d.rdy + 2'd1;
            if (fw_set_ready)
                fill_clr = 1'b1;
        end

        if (fw_flush) begin
            if (st_d.rdy != 2'd0) begin
                st_d.rdy      = st_d.rdy - 2'd1;
                st_d.inflight = 1'b0;
            end else begin
                fill_clr = 1'b1;
            end
        end

        if (fw_force_tog) begin
            st_d.tog      = ~st_d.tog;
            st_d.inflight = 1'b0;
            if (st_d.rdy != 2'd0)
                st_d.rdy = st_d.rdy - 2'd1;
        end

        if (fw_clr_tog)
            st_d.tog = 1'b0;
        if (fw_clr_sent_stall)
            st_d.sent_stall = 1'b0;
        if (fw_clr_underrun)
            st_d.underrun = 1'b0;

        st_d.irq = event_irq && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{rdy: 2'd0, tog: 1'b0, inflight: 1'b0, sent_stall: 1'b0,
                      underrun: 1'b0, rv: 1'b0, kind: RESP_DATA, rtog: 1'b0, irq: 1'b0};
        else
            st_q <= st_d;
    end

    assign resp_valid  = st_q.rv;
    assign resp_kind   = st_q.kind;
    assign resp_tog    = st_q.rtog;
    assign pkt_ready   = st_q.rdy != 2'd0;
    assign pkt_present = (st_q.rdy != 2'd0) || partial;
    assign sent_stall  = st_q.sent_stall;
    assign underrun    = st_q.underrun;
    assign data_tog    = st_q.tog;
    assign irq         = st_q.irq;

    // R3
    tok_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_in |=> resp_valid);

    // R7
    stall_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == RESP_STALL) |-> (sent_stall && !pkt_ready));

    // R6
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_kind == RESP_NAK || resp_kind == RESP_ZLP)) |-> underrun);

    // R8
    iso_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == RESP_STALL) |-> !$past(cfg_iso));

    // R14
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R11
    clr_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_clr_tog && !fw_force_tog) |=> !data_tog);
endmodule

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_iso = 0, cfg_dbl_buf = 0, cfg_auto_ready = 0, cfg_stall = 0, irq_en = 1;
    logic [7:0] cfg_max_units = 8'd1;
    logic       fw_set_ready = 0, fw_flush = 0, fw_clr_tog = 0, fw_force_tog = 0;
    logic       fw_clr_sent_stall = 0, fw_clr_underrun = 0, load_byte = 0, tok_in = 0, host_ack = 0;
    logic       resp_valid, resp_tog, pkt_ready, pkt_present, sent_stall, underrun, data_tog, irq;
    logic [1:0] resp_kind;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_rdy = 0, m_fill = 0, m_tog = 0, m_fly = 0, m_ss = 0, m_un = 0;
    int m_rv = 0, m_kind = 0, m_rtog = 0, m_irq = 0;

    always #4 clk = ~clk; // 125 MHz

    usb_in_ep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_dbl_buf(cfg_dbl_buf),
        .cfg_auto_ready(cfg_auto_ready), .cfg_max_units(cfg_max_units), .cfg_stall(cfg_stall),
        .irq_en(irq_en), .fw_set_ready(fw_set_ready), .fw_flush(fw_flush), .fw_clr_tog(fw_clr_tog),
        .fw_force_tog(fw_force_tog), .fw_clr_sent_stall(fw_clr_sent_stall),
        .fw_clr_underrun(fw_clr_underrun), .load_byte(load_byte), .tok_in(tok_in),
        .host_ack(host_ack), .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_tog(resp_tog),
        .pkt_ready(pkt_ready), .pkt_present(pkt_present), .sent_stall(sent_stall),
        .underrun(underrun), .data_tog(data_tog), .irq(irq)
    );

    // Reference model: one step per clock, from the requirement text
    always @(posedge clk) begin
        int room;
        int old_rdy;
        bit ev;
        if (!rst_n) begin
            m_rdy = 0; m_fill = 0; m_tog = 0; m_fly = 0; m_ss = 0; m_un = 0;
            m_rv = 0; m_kind = 0; m_rtog = 0; m_irq = 0;
        end else begin
            room = cfg_dbl_buf ? 2 : 1;
            old_rdy = m_rdy;
            ev = 0;
            m_rv = 0;
            if (tok_in) begin
                m_rv = 1; m_rtog = m_tog;
                if (cfg_stall && !cfg_iso) begin
                    m_kind = 2; m_ss = 1; m_rdy = 0; m_fill = 0; m_fly = 0; ev = 1;
                end else if (m_rdy > 0) begin
                    m_kind = 0;
                    if (cfg_iso) begin m_rdy--; m_tog = 1 - m_tog; ev = 1; end
                    else m_fly = 1;
                end else begin
                    m_kind = cfg_iso ? 3 : 1; m_un = 1;
                end
            end
            if (host_ack && m_fly == 1 && !cfg_iso && m_rdy > 0) begin
                m_rdy--; m_tog = 1 - m_tog; m_fly = 0; ev = 1;
            end
            if (load_byte && old_rdy < room) begin
                m_fill++;
                if (cfg_auto_ready && m_fill == cfg_max_units * 8) begin m_rdy++; m_fill = 0; end
            end
            if (fw_set_ready && old_rdy < room) begin m_rdy++; m_fill = 0; end
            if (fw_flush) begin
                if (m_rdy > 0) begin m_rdy--; m_fly = 0; end else m_fill = 0;
            end
            if (fw_force_tog) begin
                m_tog = 1 - m_tog; m_fly = 0; if (m_rdy > 0) m_rdy--;
            end
            if (fw_clr_tog) m_tog = 0;
            if (fw_clr_sent_stall) m_ss = 0;
            if (fw_clr_underrun) m_un = 0;
            m_irq = (ev && irq_en) ? 1 : 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R2 pkt_ready", int'(pkt_ready), (m_rdy > 0) ? 1 : 0);
            chk("R13 pkt_present", int'(pkt_present), (m_rdy > 0 || m_fill > 0) ? 1 : 0);
            chk("R4 data_tog", int'(data_tog), m_tog);
            chk("R3 resp_valid", int'(resp_valid), m_rv);
            chk("R7 sent_stall", int'(sent_stall), m_ss);
            chk("R6 underrun", int'(underrun), m_un);
            chk("R14 irq", int'(irq), m_irq);
            if (m_rv == 1) begin
                chk("R3 resp_kind", int'(resp_kind), m_kind);
                chk("R3 resp_tog", int'(resp_tog), m_rtog);
            end
        end
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // one-cycle pulse: 0 ready,1 flush,2 clrtog,3 force,4 clrss,5 clrun,6 byte,7 tok,8 ack
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: fw_set_ready = 1; 1: fw_flush = 1; 2: fw_clr_tog = 1; 3: fw_force_tog = 1;
            4: fw_clr_sent_stall = 1; 5: fw_clr_underrun = 1; 6: load_byte = 1;
            7: tok_in = 1; default: host_ack = 1;
        endcase
        @(negedge clk);
        fw_set_ready = 0; fw_flush = 0; fw_clr_tog = 0; fw_force_tog = 0;
        fw_clr_sent_stall = 0; fw_clr_underrun = 0; load_byte = 0; tok_in = 0; host_ack = 0;
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) pulse(6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pkt_ready", int'(pkt_ready), 0);
        chk("R1 data_tog", int'(data_tog), 0);
        chk("R1 flags", int'(sent_stall) + int'(underrun) + int'(irq) + int'(resp_valid), 0);
        rst_n = 1;
        @(negedge clk);

        // R2, R3, R4: bulk send and ack
        load(3); pulse(0);
        chk("R2 ready after commit", int'(pkt_ready), 1);
        pulse(7);
        chk("R3 data reply", int'(resp_kind), 0);
        pulse(8);
        chk("R4 toggle after ack", int'(data_tog), 1);
        pulse(8); // R4: ack with nothing in flight
        chk("R4 stray ack", int'(data_tog), 1);

        // R6: underrun NAK in bulk
        pulse(7);
        chk("R6 NAK", int'(resp_kind), 1);
        pulse(5);
        chk("R6 cleared", int'(underrun), 0);

        // R2, R9: double buffering and flush
        cfg_dbl_buf = 1;
        load(2); pulse(0); load(2); pulse(0); pulse(0);
        chk("R2 two slots", int'(pkt_ready), 1);
        pulse(1);
        chk("R9 one flush leaves one", int'(pkt_ready), 1);
        pulse(1);
        chk("R9 second flush empties", int'(pkt_ready), 0);
        load(2); pulse(1);
        chk("R9 flush drops partial", int'(pkt_present), 0);

        // R10, R13: auto commit on the eighth byte of one unit
        cfg_auto_ready = 1;
        load(7);
        chk("R13 partial present", int'(pkt_present), 1);
        chk("R10 not yet ready", int'(pkt_ready), 0);
        load(1);
        chk("R10 auto ready", int'(pkt_ready), 1);
        cfg_auto_ready = 0;

        // R12, R11: force toggle drops, clear toggle
        pulse(3);
        chk("R12 force drops", int'(pkt_ready), 0);
        pulse(3);
        pulse(2);
        chk("R11 toggle zero", int'(data_tog), 0);

        // R7: stall drops both slots
        pulse(0); pulse(0); load(1);
        cfg_stall = 1;
        pulse(7);
        chk("R7 stall reply", int'(resp_kind), 2);
        chk("R7 emptied", int'(pkt_present), 0);
        pulse(4);
        chk("R7 flag cleared", int'(sent_stall), 0);

        // R5, R8: isochronous ignores stall, retires at send
        cfg_iso = 1;
        pulse(0);
        pulse(7);
        chk("R8 data despite stall", int'(resp_kind), 0);
        chk("R5 retired at send", int'(pkt_ready), 0);
        pulse(7);
        chk("R6 zero-length reply", int'(resp_kind), 3);
        pulse(5);

        // R14: interrupt suppressed
        irq_en = 0;
        pulse(0); pulse(7);
        chk("R14 no irq", int'(irq), 0);
        cfg_iso = 0; cfg_stall = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule